// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block gives a host three independent 16-bit down-counters behind a byte-wide register bus. Two address bits pick one of four ports: ports 0, 1 and 2 are the data ports of channels 0, 1 and 2, and port 3 is a shared command port. A command byte either programs one channel or latches values for later reads. Programming sets the channel's operating mode and the order in which count bytes pass through its data port. A latch can freeze one channel's count, or a multi-channel read-back can freeze the count and/or a status byte of several channels at once.

Each channel counts only in cycles where its clock-enable input is high. It has a gate input and drives one output pin. Three operating modes are supported: mode 0 (terminal-count interrupt), mode 1 (gate-triggered one-shot) and mode 2 (rate generator). Any command that asks for another mode or for decimal (BCD) counting is refused, and the channel keeps its present setup.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, every channel is in mode 0 with access mode 3, its output pin is low, its null-count flag is clear, and its status byte reads 0x30.
- R2: A byte written to port 3 with bits 7:6 below 3 programs that channel. Bit 0 is the BCD flag, bits 3:1 the mode, and bits 5:4 the access mode (0 latch count, 1 low byte only, 2 high byte only, 3 low then high). On the next clock edge the output pin goes low for mode 0 and high for modes 1 and 2. The count then stays unloaded until a new reload value is written.
- R3: A programming command whose mode field is above 2, or whose BCD bit is 1, changes nothing. The channel keeps its mode, access mode and output.
- R4: A data-port write sets the reload value. In access mode 1 the value is {0x00, byte}. In access mode 2 it is {byte, 0x00}. In access mode 3 the first byte is the low half and the second byte the high half, and the value takes effect only with the second byte.
- R5: Mode 0: a reload write drives the output low. The counter loads the reload value at the next enabled cycle, then decrements on each enabled cycle with the gate high. The output goes high on the step from 1 to 0 and stays high.
- R6: Mode 2: the first reload write loads at the next enabled cycle. The output is low for exactly the span in which the count holds 1. The next enabled, gated cycle then reloads the count and raises the output. A reload written while the channel is counting is used at the next reload.
- R7: Mode 1: on an enabled cycle the gate is sampled. If it is high after being low at the previous enabled cycle, and a reload value has been written, the count is loaded and the output goes low. The output goes high on the step from 1 to 0.
- R8: In every mode, an enabled cycle with the gate low leaves the count unchanged.
- R9: Access mode 0 in a programming byte latches the channel's count and leaves its mode unchanged. The latched value stays frozen until it has been fully read (one byte in access modes 1 and 2, two bytes in access mode 3). A further latch request before that is ignored.
- R10: A byte on port 3 with bits 7:6 equal to 3 is a read-back. Bit 0 must be 0, or the byte is ignored. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low latches the count and bit 4 low latches the status. A latched status is returned by the next data-port read, ahead of any count byte.
- R11: The status byte has the output pin in bit 7, the null-count flag in bit 6, and the programmed access mode, mode and BCD bit in bits 5:4, 3:1 and 0. Null count is set by a completed reload write and cleared when that value enters the counter.
- R12: Count reads follow the access mode: low byte only, high byte only, or alternating low then high in mode 3. A read of port 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Port select: 0..2 channel data, 3 command |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port, valid during the read cycle |
| cnt_en | input | 3 | Per-channel count enable |
| gate | input | 3 | Per-channel gate input |
| tmr_out | output | 3 | Per-channel output pin |

## Verification
A reference model in the bench tracks every channel and compares all three output pins on every clock, and every read byte as well. The directed patterns are these:
- A short mode-0 count tells whether the edge at which the output rises is the load cycle or the last decrement.
- A reload of 4 in mode 2 shows whether the low pulse sits on count 1 and lasts exactly one enabled cycle.
- A gate held low and then raised in mode 1 separates level triggering from edge triggering.
- Latches followed by live counting show whether a latch really freezes the value and whether a second request is ignored.

A long random phase then mixes enables, gates, arbitrary command bytes, data writes and reads. It reaches orderings the directed part does not: reprogramming during a count, and reads split across byte sequences.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_LOHI  = 2'd3
   } acc_e;

   localparam logic [2:0] MD_TERM    = 3'd0;
   localparam logic [2:0] MD_ONESHOT = 3'd1;
   localparam logic [2:0] MD_RATE    = 3'd2;
   localparam logic [1:0] SEL_CMD    = 2'd3;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [7:0]        cmd_byte,
   output logic [NUM_CH-1:0] prog,
   output logic [NUM_CH-1:0] lc_req,
   output logic [NUM_CH-1:0] ls_req,
   output logic [2:0]        prog_mode,
   output acc_e              prog_acc
);
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("tmr_cmd_decode: NUM_CH must be 1..3");
   end

   logic [1:0] chan;
   logic       is_rb;
   logic       mode_ok;
   logic       rb_ok;

   assign chan      = cmd_byte[7:6];
   assign is_rb     = (chan == SEL_CMD);
   assign prog_mode = cmd_byte[3:1];
   assign prog_acc  = acc_e'(cmd_byte[5:4]);
   assign mode_ok   = (cmd_byte[3:1] <= MD_RATE) && !cmd_byte[0];
   assign rb_ok     = cmd_wr && is_rb && !cmd_byte[0];

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_req
      logic hit;
      assign hit = cmd_wr && !is_rb && (chan == 2'(gi));
      assign prog[gi]   = hit && (prog_acc != ACC_LATCH) && mode_ok;
      assign lc_req[gi] = (hit && (prog_acc == ACC_LATCH)) ||
                          (rb_ok && cmd_byte[gi+1] && !cmd_byte[5]);
      assign ls_req[gi] = rb_ok && cmd_byte[gi+1] && !cmd_byte[4];
   end

   // R2: at most one channel is programmed by a command byte
   assert_one_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prog));

   // R3: a refused mode or BCD request never reaches a channel
   assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prog != '0) |-> (cmd_byte[3:1] <= 3'd2 && !cmd_byte[0]));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              gate,
   input  logic              prog,
   input  logic [2:0]        prog_mode,
   input  acc_e              prog_acc,
   input  logic              lc_req,
   input  logic              ls_req,
   input  logic              dwr,
   input  logic              drd,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              out_pin
);
   if (CNT_W != 2 * BYTE_W) begin : g_bad_w
      $error("tmr_channel: CNT_W must be twice BYTE_W");
   end
   if (BYTE_W != 8) begin : g_bad_b
      $error("tmr_channel: status byte needs BYTE_W of 8");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   logic [2:0]        mode_q;
   acc_e              acc_q;
   logic              out_q, null_q, armed_q, written_q, pend_q;
   logic              wr_hi_q, rd_hi_q, gate_prev_q;
   logic              cl_vld_q, sl_vld_q;
   logic [CNT_W-1:0]  cnt_q, reload_q, cl_q;
   logic [BYTE_W-1:0] lo_q, sl_q;
   logic              wr_load;
   logic [CNT_W-1:0]  wr_val;
   logic [CNT_W-1:0]  rd_src;
   logic [7:0]        status_w;
   logic              rise;

   assign status_w = {out_q, null_q, acc_q, mode_q, 1'b0};
   assign rise     = gate && !gate_prev_q;
   assign out_pin  = out_q;

   always_comb begin
      wr_load = 1'b0;
      wr_val  = '0;
      if (dwr) begin
         case (acc_q)
            ACC_LO:   begin wr_load = 1'b1; wr_val = {{BYTE_W{1'b0}}, wdata}; end
            ACC_HI:   begin wr_load = 1'b1; wr_val = {wdata, {BYTE_W{1'b0}}}; end
            ACC_LOHI: begin wr_load = wr_hi_q; wr_val = {wdata, lo_q}; end
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_src = cl_vld_q ? cl_q : cnt_q;
      if (sl_vld_q)
         rdata = sl_q;
      else if (acc_q == ACC_HI || (acc_q == ACC_LOHI && rd_hi_q))
         rdata = rd_src[CNT_W-1:BYTE_W];
      else
         rdata = rd_src[BYTE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MD_TERM;      acc_q <= ACC_LOHI;
         out_q <= 1'b0;          null_q <= 1'b0;
         armed_q <= 1'b0;        written_q <= 1'b0;
         pend_q <= 1'b0;         wr_hi_q <= 1'b0;
         rd_hi_q <= 1'b0;        gate_prev_q <= 1'b0;
         cl_vld_q <= 1'b0;       sl_vld_q <= 1'b0;
         cnt_q <= '0;            reload_q <= '0;
         cl_q <= '0;             lo_q <= '0;
         sl_q <= '0;
      end else begin
         if (lc_req && !cl_vld_q) begin cl_vld_q <= 1'b1; cl_q <= cnt_q; end
         if (ls_req && !sl_vld_q) begin sl_vld_q <= 1'b1; sl_q <= status_w; end
         if (drd) begin
            if (sl_vld_q) sl_vld_q <= 1'b0;
            else begin
               if (acc_q == ACC_LOHI) rd_hi_q <= !rd_hi_q;
               if (acc_q != ACC_LOHI || rd_hi_q) cl_vld_q <= 1'b0;
            end
         end
         if (cnt_en) begin
            gate_prev_q <= gate;
            case (mode_q)
               MD_TERM: begin
                  if (pend_q) begin
                     cnt_q <= reload_q; pend_q <= 1'b0; null_q <= 1'b0; armed_q <= 1'b1;
                  end else if (armed_q && gate) begin
                     cnt_q <= cnt_q - ONE;
                     if (cnt_q == ONE) out_q <= 1'b1;
                  end
               end
               MD_RATE: begin
                  if (pend_q && !armed_q) begin
                     cnt_q <= reload_q; pend_q <= 1'b0; null_q <= 1'b0; armed_q <= 1'b1;
                  end else if (armed_q && gate) begin
                     if (cnt_q == ONE) begin
                        cnt_q <= reload_q; out_q <= 1'b1; null_q <= 1'b0; pend_q <= 1'b0;
                     end else begin
                        cnt_q <= cnt_q - ONE;
                        if (cnt_q == TWO) out_q <= 1'b0;
                     end
                  end
               end
               default: begin
                  if (rise && written_q) begin
                     cnt_q <= reload_q; out_q <= 1'b0; null_q <= 1'b0;
                     pend_q <= 1'b0; armed_q <= 1'b1;
                  end else if (armed_q && gate) begin
                     cnt_q <= cnt_q - ONE;
                     if (cnt_q == ONE) out_q <= 1'b1;
                  end
               end
            endcase
         end
         if (prog) begin
            mode_q <= prog_mode;   acc_q <= prog_acc;
            out_q <= (prog_mode != MD_TERM);
            armed_q <= 1'b0;       pend_q <= 1'b0;
            written_q <= 1'b0;     wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end
         if (dwr && acc_q == ACC_LOHI) begin
            wr_hi_q <= !wr_hi_q;
            if (!wr_hi_q) lo_q <= wdata;
         end
         if (wr_load) begin
            reload_q <= wr_val; null_q <= 1'b1; pend_q <= 1'b1; written_q <= 1'b1;
            if (mode_q == MD_TERM) out_q <= 1'b0;
         end
      end
   end

   // R2: programming sets the output level chosen by the new mode
   assert_prog_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && prog_mode == MD_TERM) |=> !out_q);
   assert_prog_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && prog_mode != MD_TERM) |=> out_q);

   // R6: in rate mode the output is only low while the count holds 1
   assert_rate_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RATE && !out_q) |-> (cnt_q == ONE));

   // R8: a low gate holds a running count
   assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !pend_q && !gate && !prog) |=> $stable(cnt_q));

   // R9: a latched count does not move until it is released
   assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_vld_q && $past(cl_vld_q)) |-> $stable(cl_q));

   // R5: once risen in mode 0, the output stays high until a write or reprogram
   assert_term_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_TERM && out_q && !prog && !wr_load) |=> out_q);
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] cnt_en,
   input  logic [NUM_CH-1:0] gate,
   output logic [NUM_CH-1:0] tmr_out
);
   logic [NUM_CH-1:0] prog, lc_req, ls_req;
   logic [2:0]        prog_mode;
   acc_e              prog_acc;
   logic [BYTE_W-1:0] ch_rd [NUM_CH];

   tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (bus_wr && bus_sel == SEL_CMD),
      .cmd_byte  (bus_wdata),
      .prog      (prog),
      .lc_req    (lc_req),
      .ls_req    (ls_req),
      .prog_mode (prog_mode),
      .prog_acc  (prog_acc)
   );

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_en    (cnt_en[gi]),
         .gate      (gate[gi]),
         .prog      (prog[gi]),
         .prog_mode (prog_mode),
         .prog_acc  (prog_acc),
         .lc_req    (lc_req[gi]),
         .ls_req    (ls_req[gi]),
         .dwr       (bus_wr && bus_sel == 2'(gi)),
         .drd       (bus_rd && bus_sel == 2'(gi)),
         .wdata     (bus_wdata),
         .rdata     (ch_rd[gi]),
         .out_pin   (tmr_out[gi])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (bus_sel == 2'(i)) bus_rdata = ch_rd[i];
   end
endmodule

// File: tb/tri_interval_timer_tb.sv
module tri_interval_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_sel = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] cnt_en = '0, gate = '0;
   logic [2:0] tmr_out;

   int vectors = 0, miscompares = 0;
   logic [2:0] cur_en = '0, cur_g = '0;

   // behavioural reference state, one entry per channel
   int mm[3], ma[3], mo[3], mn[3], marm[3], mwr[3], mp[3], mc[3], mr[3];
   int mlo[3], mwh[3], mrh[3], mclv[3], mcl[3], mslv[3], msl[3], mgp[3];

   always #2 clk = ~clk;

   tri_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en), .gate(gate),
      .tmr_out(tmr_out));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int m_rdata(input int ch);
      int v;
      if (ch == 3) return 0;
      if (mslv[ch] != 0) return msl[ch];
      v = (mclv[ch] != 0) ? mcl[ch] : mc[ch];
      if (ma[ch] == 2 || (ma[ch] == 3 && mrh[ch] != 0)) return (v >> 8) & 255;
      return v & 255;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 3; i++) begin
         mm[i] = 0; ma[i] = 3; mo[i] = 0; mn[i] = 0; marm[i] = 0; mwr[i] = 0; mp[i] = 0;
         mc[i] = 0; mr[i] = 0; mlo[i] = 0; mwh[i] = 0; mrh[i] = 0; mclv[i] = 0; mcl[i] = 0;
         mslv[i] = 0; msl[i] = 0; mgp[i] = 0;
      end
   endtask

   task automatic m_step(input int sel, input bit wr, input bit rd, input int wd,
                         input logic [2:0] en, input logic [2:0] g);
      int ch, acc, md;
      ch = (wd >> 6) & 3; acc = (wd >> 4) & 3; md = (wd >> 1) & 7;
      if (wr && sel == 3) begin
         for (int i = 0; i < 3; i++) begin
            bit lc, ls;
            lc = (ch == 3) ? ((wd & 1) == 0 && ((wd >> (i + 1)) & 1) == 1 && ((wd >> 5) & 1) == 0)
                           : (ch == i && acc == 0);
            ls = (ch == 3) && (wd & 1) == 0 && ((wd >> (i + 1)) & 1) == 1 && ((wd >> 4) & 1) == 0;
            if (lc && mclv[i] == 0) begin mclv[i] = 1; mcl[i] = mc[i]; end
            if (ls && mslv[i] == 0) begin
               mslv[i] = 1; msl[i] = mo[i] * 128 + mn[i] * 64 + ma[i] * 16 + mm[i] * 2;
            end
         end
      end
      if (rd && sel < 3) begin
         if (mslv[sel] != 0) mslv[sel] = 0;
         else begin
            if (ma[sel] != 3 || mrh[sel] != 0) mclv[sel] = 0;
            if (ma[sel] == 3) mrh[sel] = 1 - mrh[sel];
         end
      end
      for (int i = 0; i < 3; i++) begin
         if (en[i]) begin
            bit gb, rise;
            gb = g[i]; rise = gb && mgp[i] == 0; mgp[i] = gb;
            if (mm[i] == 0) begin
               if (mp[i] != 0) begin mc[i] = mr[i]; mp[i] = 0; mn[i] = 0; marm[i] = 1; end
               else if (marm[i] != 0 && gb) begin
                  if (mc[i] == 1) mo[i] = 1;
                  mc[i] = (mc[i] + 65535) % 65536;
               end
            end else if (mm[i] == 2) begin
               if (mp[i] != 0 && marm[i] == 0) begin mc[i] = mr[i]; mp[i] = 0; mn[i] = 0; marm[i] = 1; end
               else if (marm[i] != 0 && gb) begin
                  if (mc[i] == 1) begin mc[i] = mr[i]; mo[i] = 1; mn[i] = 0; mp[i] = 0; end
                  else begin
                     if (mc[i] == 2) mo[i] = 0;
                     mc[i] = (mc[i] + 65535) % 65536;
                  end
               end
            end else begin
               if (rise && mwr[i] != 0) begin
                  mc[i] = mr[i]; mo[i] = 0; mn[i] = 0; mp[i] = 0; marm[i] = 1;
               end else if (marm[i] != 0 && gb) begin
                  if (mc[i] == 1) mo[i] = 1;
                  mc[i] = (mc[i] + 65535) % 65536;
               end
            end
         end
      end
      if (wr && sel == 3 && ch < 3 && acc != 0 && (wd & 1) == 0 && md <= 2) begin
         mm[ch] = md; ma[ch] = acc; mo[ch] = (md == 0) ? 0 : 1;
         marm[ch] = 0; mp[ch] = 0; mwr[ch] = 0; mwh[ch] = 0; mrh[ch] = 0;
      end
      if (wr && sel < 3) begin
         bit ld; int v;
         ld = 0; v = 0;
         if (ma[sel] == 1) begin ld = 1; v = wd & 255; end
         else if (ma[sel] == 2) begin ld = 1; v = (wd & 255) * 256; end
         else if (ma[sel] == 3) begin
            if (mwh[sel] == 0) begin mlo[sel] = wd & 255; mwh[sel] = 1; end
            else begin ld = 1; v = (wd & 255) * 256 + mlo[sel]; mwh[sel] = 0; end
         end
         if (ld) begin
            mr[sel] = v; mn[sel] = 1; mp[sel] = 1; mwr[sel] = 1;
            if (mm[sel] == 0) mo[sel] = 0;
         end
      end
   endtask

   task automatic cyc(input int sel, input bit wr, input bit rd, input int wd, input string tag);
      bus_sel = sel[1:0]; bus_wr = wr; bus_rd = rd; bus_wdata = wd[7:0];
      cnt_en = cur_en; gate = cur_g;
      #1;
      if (rd) chk(tag, "read data", int'(bus_rdata), m_rdata(sel));
      @(posedge clk);
      m_step(sel, wr, rd, wd, cur_en, cur_g);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      for (int i = 0; i < 3; i++) chk(tag, $sformatf("out%0d", i), int'(tmr_out[i]), mo[i]);
   endtask

   task automatic run(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, tag);
   endtask
   task automatic wcmd(input int b, input string tag); cyc(3, 1, 0, b, tag); endtask
   task automatic wdat(input int ch, input int b, input string tag); cyc(ch, 1, 0, b, tag); endtask
   task automatic rdat(input int ch, input string tag); cyc(ch, 0, 1, 0, tag); endtask

   initial begin
      #(200000 * 4);
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset outputs and status of every channel
      run(2, "R1");
      wcmd(8'hEE, "R1");
      for (int i = 0; i < 3; i++) begin
         chk("R1", "reset status model", m_rdata(i), 8'h30);
         rdat(i, "R1");
      end
      // R2: program the three modes
      wcmd(8'h30, "R2"); wcmd(8'h54, "R2"); wcmd(8'hB2, "R2");
      cur_en = 3'b111; cur_g = 3'b011;
      // R4/R5: low-then-high count of 5 in mode 0
      wdat(0, 8'h05, "R4"); run(2, "R4"); wdat(0, 8'h00, "R4");
      run(10, "R5");
      // R6: rate generator with reload 4
      wdat(1, 8'h04, "R6"); run(14, "R6");
      // R8: gate low holds everything
      cur_g = 3'b000; run(6, "R8"); cur_g = 3'b011; run(3, "R8");
      // R7: one-shot triggered by gate rise
      wdat(2, 8'h03, "R7"); wdat(2, 8'h00, "R7"); run(3, "R7");
      cur_g = 3'b111; run(8, "R7");
      // R3: refused mode and BCD, then status of channel 0
      wcmd(8'h36, "R3"); wcmd(8'h31, "R3"); run(2, "R3");
      wcmd(8'hE2, "R3"); rdat(0, "R3");
      // R4: high byte only
      wcmd(8'h20, "R4"); wdat(0, 8'h01, "R4"); run(3, "R4"); rdat(0, "R4");
      // R9: count latch, second latch ignored, two-byte read
      wcmd(8'h30, "R9"); wdat(0, 8'h34, "R9"); wdat(0, 8'h12, "R9"); run(4, "R9");
      wcmd(8'h00, "R9"); run(3, "R9"); wcmd(8'h00, "R9"); run(2, "R9");
      rdat(0, "R9"); run(1, "R9"); rdat(0, "R9");
      rdat(0, "R12"); rdat(0, "R12");
      // R10: read-back of count and status on channels 1 and 2
      wcmd(8'hCC, "R10"); run(2, "R10");
      rdat(1, "R10"); rdat(1, "R10"); rdat(1, "R10");
      rdat(2, "R10"); rdat(2, "R10"); rdat(2, "R10");
      wcmd(8'hCD, "R10"); run(2, "R10"); rdat(2, "R10"); rdat(2, "R10");
      // R11: null-count flag across a reload transfer
      cur_en = 3'b000;
      wdat(2, 8'h09, "R11"); wdat(2, 8'h00, "R11");
      wcmd(8'hE8, "R11"); rdat(2, "R11");
      cur_en = 3'b111; cur_g = 3'b011; run(2, "R11"); cur_g = 3'b111; run(2, "R11");
      wcmd(8'hE8, "R11"); rdat(2, "R11");
      // R12: command port reads zero
      rdat(3, "R12");
      // mixed traffic
      for (int k = 0; k < 3000; k++) begin
         int r;
         r = $urandom % 16;
         cur_en = 3'($urandom); cur_g = 3'($urandom | $urandom);
         if (r == 0) wcmd($urandom % 256, "R2");
         else if (r == 1) wdat($urandom % 3, $urandom % 8, "R4");
         else if (r == 2) rdat($urandom % 4, "R12");
         else run(1, "R6");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule